// File: doc/BRIEF.md
# Dual-Bank Maskable Interrupt Controller

This block collects forty level-sensitive interrupt lines into two 32-bit banks. Lines 0 to 31 sit in bank 0. Lines 32 to 39 sit in bits 0 to 7 of bank 1. Each line has a per-bit enable and a per-bit routing choice. The routing choice sends the line to the fast interrupt output (`fiq_o`) or to the normal interrupt output (`irq_o`). A third output, `wake_o`, asks a halted core to resume. A control bit decides whether wake-up obeys the enables or accepts any pending line.

Software reaches the block through a plain strobe interface: `wr_en` or `rd_en`, a byte offset and a data word. Read data is combinational while `rd_en` is high and zero otherwise. Writes take effect at the clock edge where `wr_en` is sampled high. The pending state has no latch. It mirrors the input pins one clock later, so clearing an interrupt is done at the source.

Top module: `irq_bank_ctrl`

## Requirements
- R1: Source n maps to bank n/32, bit n%32. In bank 1 only bits 0..7 exist: they read as 0 and ignore written ones.
- R2: The raw pending word reflects the input pins sampled at the previous clock edge. A line that falls clears its bit with no latching. Offsets: 0x10 for bank 0, 0xAC for bank 1.
- R3: `fiq_o` is registered. One clock after a pending bit changes, or after an enable or routing bit changes, `fiq_o` is high exactly when some line is pending, enabled and routed to fast (routing bit = 1).
- R4: `irq_o` is registered with the same timing as `fiq_o`. It is high exactly when some line is pending, enabled and has routing bit 0.
- R5: The filtered reads are pending AND enable AND NOT routing at 0x00 / 0x9C, and pending AND enable AND routing at 0x0C / 0xA8.
- R6: The enable word (0x04 / 0xA0) and the routing word (0x08 / 0xA4) are read/write per bank. An enable bit of 1 unmasks the line. A routing bit of 1 selects the fast output.
- R7: Control bit 0 at offset 0x14 selects the wake behaviour. Value 1 means wake obeys the enables. Value 0 means any pending line wakes the core. A read returns this bit in bit 0, with all other bits 0, and its reset value is 1.
- R8: `wake_o` is registered. It is high one clock after `core_halted` is high and, in either bank, pending AND (enable OR override) is nonzero. The override is all ones when control bit 0 is 0.
- R9: A synchronous active-low reset clears the enable, routing and pending words and all three outputs.
- R10: A write to a read-only offset (0x00, 0x0C, 0x10, 0x9C, 0xA8, 0xAC) or to an unmapped offset changes nothing. A read of an unmapped offset returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_in | input | 40 | Level-sensitive interrupt lines |
| core_halted | input | 1 | High while the core is idle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid while `rd_en` is high |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |
| wake_o | output | 1 | Wake request for a halted core |

## Verification
The hardest case to reach is a line that is pending but masked, which can still raise `wake_o` through the override. Reaching it needs a specific ordering of steps:
- Clear every enable.
- Raise a pin.
- Assert `core_halted`.
- Toggle the control bit.

The bench then checks that `fiq_o` and `irq_o` stay low while `wake_o` follows the control bit. It runs this case for a bank-0 line and for a bank-1 line. Every source is also swept alone under all four enable/routing combinations. This exposes any wrong bank or bit placement and any latching of a line that has dropped.

// File: rtl/irqc_pkg.sv
// Package: shared offsets, register kinds and the bank address layout of the
// dual-bank interrupt controller. Assumes byte offsets fit in eight bits.
package irqc_pkg;

    localparam int unsigned ADDR_W = 8;

    // Offsets inside one bank window, relative to the bank base
    localparam logic [ADDR_W-1:0] REL_PIRQ  = 8'h00;
    localparam logic [ADDR_W-1:0] REL_MASK  = 8'h04;
    localparam logic [ADDR_W-1:0] REL_STEER = 8'h08;
    localparam logic [ADDR_W-1:0] REL_PFIQ  = 8'h0C;
    localparam logic [ADDR_W-1:0] REL_RAW   = 8'h10;

    // Shared wake control word and the start of the second bank window
    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h14;
    localparam logic [ADDR_W-1:0] BANK1_BASE = 8'h9C;
    localparam logic [ADDR_W-1:0] BANK_SPAN  = 8'h14;

    typedef enum logic [2:0] {
        K_NONE,
        K_PIRQ,
        K_MASK,
        K_STEER,
        K_PFIQ,
        K_RAW,
        K_CTRL
    } reg_kind_e;

    // Base offset of bank b: bank 0 at zero, later banks from BANK1_BASE on
    function automatic logic [ADDR_W-1:0] bank_base(input int unsigned b);
        if (b == 0) begin
            return '0;
        end
        return ADDR_W'(BANK1_BASE + (b - 1) * BANK_SPAN);
    endfunction

endpackage

// File: rtl/irqc_decode.sv
// Module: irqc_decode
// Turns a byte offset into a register kind and a bank index.
// Assumes bank windows do not overlap each other or the control offset.
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int SEL_W     = 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [SEL_W-1:0]  sel
);

    // Compare the offset against every bank window and the control word
    always_comb begin
        kind = K_NONE;
        sel  = '0;
        if (addr == OFS_CTRL) begin
            kind = K_CTRL;
        end
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'(bank_base(b) + REL_PIRQ)) begin
                kind = K_PIRQ;
                sel  = SEL_W'(b);
            end
            if (addr == ADDR_W'(bank_base(b) + REL_MASK)) begin
                kind = K_MASK;
                sel  = SEL_W'(b);
            end
            if (addr == ADDR_W'(bank_base(b) + REL_STEER)) begin
                kind = K_STEER;
                sel  = SEL_W'(b);
            end
            if (addr == ADDR_W'(bank_base(b) + REL_PFIQ)) begin
                kind = K_PFIQ;
                sel  = SEL_W'(b);
            end
            if (addr == ADDR_W'(bank_base(b) + REL_RAW)) begin
                kind = K_RAW;
                sel  = SEL_W'(b);
            end
        end
    end

endmodule

// File: rtl/irqc_bank.sv
// Module: irqc_bank
// One bank of interrupt state. It holds the pending bits, which sample the
// pins every clock, plus the enable and routing words. It also produces the
// two filtered pending views. Only the low IMPL bits exist; the others are
// held at zero. Assumes a synchronous active-low reset.
module irqc_bank #(
    parameter int W    = 32,
    parameter int IMPL = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic         mask_we,
    input  logic         steer_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] steer_o,
    output logic [W-1:0] pirq_o,
    output logic [W-1:0] pfiq_o
);

    localparam logic [W-1:0] IMPL_MASK =
        (IMPL >= W) ? {W{1'b1}} : W'((64'd1 << IMPL) - 64'd1);

    logic [W-1:0] pend_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] steer_q;

    // Pending bits follow the pin levels with one clock of delay
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
        end else begin
            pend_q <= pins & IMPL_MASK;
        end
    end

    // Enable and routing words take software writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q  <= '0;
            steer_q <= '0;
        end else begin
            if (mask_we) begin
                mask_q <= wdata & IMPL_MASK;
            end
            if (steer_we) begin
                steer_q <= wdata & IMPL_MASK;
            end
        end
    end

    // Filtered views for the normal and fast pending reads
    always_comb begin
        pirq_o = pend_q & mask_q & ~steer_q;
        pfiq_o = pend_q & mask_q & steer_q;
    end

    assign pend_o  = pend_q;
    assign mask_o  = mask_q;
    assign steer_o = steer_q;

endmodule

// File: rtl/irqc_out.sv
// Module: irqc_out
// Reduces the flattened bank state to the three CPU-facing requests and
// registers them. Assumes the vectors are already zero in unused bits.
module irqc_out #(
    parameter int N = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pend,
    input  logic [N-1:0] mask,
    input  logic [N-1:0] steer,
    input  logic         idle_obey,
    input  logic         core_halted,
    output logic         fiq_o,
    output logic         irq_o,
    output logic         wake_o
);

    logic [N-1:0] live;
    logic [N-1:0] wake_mask;

    // Enabled pending lines, and the wider set allowed to wake the core
    always_comb begin
        live      = pend & mask;
        wake_mask = mask | {N{~idle_obey}};
    end

    // Register the three requests
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fiq_o  <= 1'b0;
            irq_o  <= 1'b0;
            wake_o <= 1'b0;
        end else begin
            fiq_o  <= |(live & steer);
            irq_o  <= |(live & ~steer);
            wake_o <= core_halted && (|(pend & wake_mask));
        end
    end

endmodule

// File: rtl/irq_bank_ctrl.sv
// Module: irq_bank_ctrl (top)
// Dual-bank maskable interrupt controller. It builds the banks, decodes the
// register strobes, holds the wake control bit and multiplexes read data.
// Assumes single-cycle strobes and a synchronous active-low reset.
module irq_bank_ctrl
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 40,
    parameter int BANK_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic               core_halted,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BANK_W-1:0]  wdata,
    output logic [BANK_W-1:0]  rdata,
    output logic               fiq_o,
    output logic               irq_o,
    output logic               wake_o
);

    localparam int NUM_BANKS = (NUM_SRC + BANK_W - 1) / BANK_W;
    localparam int PAD_W     = NUM_BANKS * BANK_W;
    localparam int SEL_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

    reg_kind_e          kind;
    logic [SEL_W-1:0]   sel;
    logic               idle_obey;
    logic [PAD_W-1:0]   pins_pad;
    logic [PAD_W-1:0]   pend_pad;
    logic [PAD_W-1:0]   mask_pad;
    logic [PAD_W-1:0]   steer_pad;
    logic [BANK_W-1:0]  pend_w  [NUM_BANKS];
    logic [BANK_W-1:0]  mask_w  [NUM_BANKS];
    logic [BANK_W-1:0]  steer_w [NUM_BANKS];
    logic [BANK_W-1:0]  pirq_w  [NUM_BANKS];
    logic [BANK_W-1:0]  pfiq_w  [NUM_BANKS];

    assign pins_pad = PAD_W'(src_in);

    irqc_decode #(
        .NUM_BANKS (NUM_BANKS),
        .SEL_W     (SEL_W)
    ) u_decode (
        .addr (addr),
        .kind (kind),
        .sel  (sel)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam int LO   = b * BANK_W;
        localparam int REM  = NUM_SRC - LO;
        localparam int IMPL = (REM >= BANK_W) ? BANK_W : REM;

        irqc_bank #(
            .W    (BANK_W),
            .IMPL (IMPL)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .pins     (pins_pad[LO +: BANK_W]),
            .mask_we  (wr_en && (kind == K_MASK)  && (sel == SEL_W'(b))),
            .steer_we (wr_en && (kind == K_STEER) && (sel == SEL_W'(b))),
            .wdata    (wdata),
            .pend_o   (pend_w[b]),
            .mask_o   (mask_w[b]),
            .steer_o  (steer_w[b]),
            .pirq_o   (pirq_w[b]),
            .pfiq_o   (pfiq_w[b])
        );

        assign pend_pad[LO +: BANK_W]  = pend_w[b];
        assign mask_pad[LO +: BANK_W]  = mask_w[b];
        assign steer_pad[LO +: BANK_W] = steer_w[b];
    end

    // Wake control bit: 1 makes wake obey the enables
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_obey <= 1'b1;
        end else if (wr_en && (kind == K_CTRL)) begin
            idle_obey <= wdata[0];
        end
    end

    // Read multiplexer, zero when idle or unmapped
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (kind)
                K_PIRQ:  rdata = pirq_w[sel];
                K_MASK:  rdata = mask_w[sel];
                K_STEER: rdata = steer_w[sel];
                K_PFIQ:  rdata = pfiq_w[sel];
                K_RAW:   rdata = pend_w[sel];
                K_CTRL:  rdata = BANK_W'(idle_obey);
                default: rdata = '0;
            endcase
        end
    end

    irqc_out #(
        .N (PAD_W)
    ) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .pend        (pend_pad),
        .mask        (mask_pad),
        .steer       (steer_pad),
        .idle_obey   (idle_obey),
        .core_halted (core_halted),
        .fiq_o       (fiq_o),
        .irq_o       (irq_o),
        .wake_o      (wake_o)
    );

endmodule

// File: rtl/irq_bank_ctrl_chk.sv
// Module: irq_bank_ctrl_chk
// Temporal checks on the interrupt controller, bound into the top module.
// Assumes the bank state is visible as zero-padded flat vectors.
module irq_bank_ctrl_chk
    import irqc_pkg::*;
#(
    parameter int PAD_W     = 64,
    parameter int NUM_BANKS = 2,
    parameter int BANK_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PAD_W-1:0]  pins_pad,
    input logic [PAD_W-1:0]  pend_pad,
    input logic [PAD_W-1:0]  mask_pad,
    input logic [PAD_W-1:0]  steer_pad,
    input logic              idle_obey,
    input logic              core_halted,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [BANK_W-1:0] wdata,
    input logic              fiq_o,
    input logic              irq_o,
    input logic              wake_o
);

    logic mask_hit;
    logic steer_hit;

    // Flag writes that may legally touch the enable or routing words
    always_comb begin
        mask_hit  = 1'b0;
        steer_hit = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (addr == ADDR_W'(bank_base(b) + REL_MASK))  mask_hit  = 1'b1;
            if (addr == ADDR_W'(bank_base(b) + REL_STEER)) steer_hit = 1'b1;
        end
    end

    assert_pend_tracks_pins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (pend_pad == $past(pins_pad)));

    assert_fiq_follows_state_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (fiq_o == (|$past(pend_pad & mask_pad & steer_pad))));

    assert_irq_follows_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_o == (|$past(pend_pad & mask_pad & ~steer_pad))));

    assert_ctrl_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (addr == OFS_CTRL)) |=> (idle_obey == $past(wdata[0])));

    assert_wake_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (wake_o == $past(core_halted &&
            (|(pend_pad & (mask_pad | {PAD_W{~idle_obey}}))))));

    assert_reset_clears_R9: assert property (@(posedge clk)
        !rst_n |=> (mask_pad == '0 && steer_pad == '0 && pend_pad == '0 &&
                    !fiq_o && !irq_o && !wake_o && idle_obey));

    assert_mask_only_by_mask_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !mask_hit) |=> $stable(mask_pad));

    assert_steer_only_by_steer_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || !steer_hit) |=> $stable(steer_pad));

endmodule

bind irq_bank_ctrl irq_bank_ctrl_chk #(
    .PAD_W     (PAD_W),
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pins_pad    (pins_pad),
    .pend_pad    (pend_pad),
    .mask_pad    (mask_pad),
    .steer_pad   (steer_pad),
    .idle_obey   (idle_obey),
    .core_halted (core_halted),
    .wr_en       (wr_en),
    .addr        (addr),
    .wdata       (wdata),
    .fiq_o       (fiq_o),
    .irq_o       (irq_o),
    .wake_o      (wake_o)
);

// File: tb/irq_bank_ctrl_test.sv
// Bench for irq_bank_ctrl: per-source sweep plus directed wake, read-only
// and reset cases. Expected values are computed from the requirements.
module irq_bank_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] src_in = '0;
    logic        core_halted = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        fiq_o;
    logic        irq_o;
    logic        wake_o;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_bank_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_in      (src_in),
        .core_halted (core_halted),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .rdata       (rdata),
        .fiq_o       (fiq_o),
        .irq_o       (irq_o),
        .wake_o      (wake_o)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        addr  = a;
        wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        rd_en = 1'b1;
        addr  = a;
        #1;
        check(tag, rdata, exp);
        rd_en = 1'b0;
    endtask

    // Two edges cover pin-to-pending plus pending-to-output
    task automatic settle;
        repeat (2) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        logic [31:0] one;
        int bk;
        int bt;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9 reset state and R7 reset value of the control bit
        check("R9 fiq after reset", 32'(fiq_o), 0);
        check("R9 irq after reset", 32'(irq_o), 0);
        check("R9 wake after reset", 32'(wake_o), 0);
        rd_check("R9 mask0", 8'h04, 0);
        rd_check("R9 mask1", 8'hA0, 0);
        rd_check("R9 steer0", 8'h08, 0);
        rd_check("R9 steer1", 8'hA4, 0);
        rd_check("R9 raw0", 8'h10, 0);
        rd_check("R7 ctrl reset", 8'h14, 1);

        // R1..R5 sweep: every source alone, all enable/routing combinations
        for (int n = 0; n < 40; n++) begin
            for (int m = 0; m < 2; m++) begin
                for (int s = 0; s < 2; s++) begin
                    bk  = n / 32;
                    bt  = n % 32;
                    one = 32'd1 << bt;
                    wr(8'h04, (bk == 0 && m == 1) ? one : 32'd0);
                    wr(8'hA0, (bk == 1 && m == 1) ? one : 32'd0);
                    wr(8'h08, (bk == 0 && s == 1) ? one : 32'd0);
                    wr(8'hA4, (bk == 1 && s == 1) ? one : 32'd0);
                    src_in = 40'd1 << n;
                    settle();
                    check($sformatf("R3 fiq src%0d m%0d s%0d", n, m, s), 32'(fiq_o), 32'(m == 1 && s == 1));
                    check($sformatf("R4 irq src%0d m%0d s%0d", n, m, s), 32'(irq_o), 32'(m == 1 && s == 0));
                    rd_check($sformatf("R1 R2 raw src%0d", n), bk ? 8'hAC : 8'h10, one);
                    rd_check($sformatf("R5 pirq src%0d", n), bk ? 8'h9C : 8'h00,
                             (m == 1 && s == 0) ? one : 32'd0);
                    rd_check($sformatf("R5 pfiq src%0d", n), bk ? 8'hA8 : 8'h0C,
                             (m == 1 && s == 1) ? one : 32'd0);
                    src_in = '0;
                    settle();
                    rd_check($sformatf("R2 raw cleared src%0d", n), bk ? 8'hAC : 8'h10, 0);
                    check($sformatf("R3 fiq drop src%0d", n), 32'(fiq_o), 0);
                    check($sformatf("R4 irq drop src%0d", n), 32'(irq_o), 0);
                end
            end
        end

        // R6 read/write words, R1 unimplemented bank-1 bits
        wr(8'h04, 32'h1234_5678);
        wr(8'h08, 32'h0F0F_0F0F);
        wr(8'hA0, 32'hFFFF_FFAB);
        wr(8'hA4, 32'h0000_FF5A);
        rd_check("R6 mask0", 8'h04, 32'h1234_5678);
        rd_check("R6 steer0", 8'h08, 32'h0F0F_0F0F);
        rd_check("R1 mask1 upper bits", 8'hA0, 32'h0000_00AB);
        rd_check("R1 steer1 upper bits", 8'hA4, 32'h0000_005A);

        // R5 mixed pattern with all lines high
        src_in = '1;
        settle();
        rd_check("R2 raw0 all", 8'h10, 32'hFFFF_FFFF);
        rd_check("R1 raw1 all", 8'hAC, 32'h0000_00FF);
        rd_check("R5 pirq0 mix", 8'h00, 32'h1234_5678 & ~32'h0F0F_0F0F);
        rd_check("R5 pfiq0 mix", 8'h0C, 32'h1234_5678 & 32'h0F0F_0F0F);
        rd_check("R5 pirq1 mix", 8'h9C, 32'hAB & ~32'h5A);
        rd_check("R5 pfiq1 mix", 8'hA8, 32'hAB & 32'h5A);
        check("R3 fiq mix", 32'(fiq_o), 1);
        check("R4 irq mix", 32'(irq_o), 1);

        // R10 writes to read-only and unmapped offsets change nothing
        wr(8'h00, '1);
        wr(8'h0C, '1);
        wr(8'h10, '1);
        wr(8'h9C, '1);
        wr(8'hA8, '1);
        wr(8'hAC, '1);
        wr(8'h18, '1);
        wr(8'h50, 32'h0);
        wr(8'hFC, '1);
        rd_check("R10 mask0 kept", 8'h04, 32'h1234_5678);
        rd_check("R10 steer0 kept", 8'h08, 32'h0F0F_0F0F);
        rd_check("R10 mask1 kept", 8'hA0, 32'h0000_00AB);
        rd_check("R10 steer1 kept", 8'hA4, 32'h0000_005A);
        rd_check("R10 ctrl kept", 8'h14, 1);
        rd_check("R10 unmapped 0x18", 8'h18, 0);
        rd_check("R10 unmapped 0x50", 8'h50, 0);
        rd_check("R10 unmapped 0xFC", 8'hFC, 0);
        rd_check("R10 raw0 kept", 8'h10, 32'hFFFF_FFFF);

        // R7 / R8: masked pending line wakes only with the override
        src_in = '0;
        wr(8'h04, 0);
        wr(8'hA0, 0);
        wr(8'h08, 0);
        wr(8'hA4, 0);
        src_in[5]   = 1'b1;
        core_halted = 1'b1;
        settle();
        check("R8 masked no wake", 32'(wake_o), 0);
        check("R4 masked no irq", 32'(irq_o), 0);
        wr(8'h14, 32'hFFFF_FFFE);
        rd_check("R7 ctrl reads 0", 8'h14, 0);
        settle();
        check("R8 override wake", 32'(wake_o), 1);
        check("R3 override no fiq", 32'(fiq_o), 0);
        wr(8'h14, 32'h1);
        rd_check("R7 ctrl reads 1", 8'h14, 1);
        settle();
        check("R8 obey no wake", 32'(wake_o), 0);
        wr(8'h04, 32'h20);
        settle();
        check("R8 enabled wake", 32'(wake_o), 1);
        check("R4 enabled irq", 32'(irq_o), 1);
        core_halted = 1'b0;
        settle();
        check("R8 not halted", 32'(wake_o), 0);
        wr(8'h04, 0);
        src_in      = '0;
        src_in[37]  = 1'b1;
        core_halted = 1'b1;
        settle();
        check("R8 bank1 masked", 32'(wake_o), 0);
        wr(8'h14, 0);
        settle();
        check("R8 bank1 override", 32'(wake_o), 1);
        src_in = '0;
        settle();
        check("R8 line dropped", 32'(wake_o), 0);

        // R9 mid-run reset
        wr(8'h04, '1);
        src_in = '1;
        settle();
        @(negedge clk);
        rst_n = 1'b0;
        settle();
        check("R9 fiq in reset", 32'(fiq_o), 0);
        check("R9 irq in reset", 32'(irq_o), 0);
        check("R9 wake in reset", 32'(wake_o), 0);
        rst_n  = 1'b1;
        src_in = '0;
        rd_check("R9 mask0 cleared", 8'h04, 0);
        rd_check("R7 ctrl back to 1", 8'h14, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule